// File: doc/BRIEF.md
# Pulse-by-Pulse Overcurrent Blanking Gate

This block sits between the PWM generator of a switching regulator and the high-side driver. Each switching cycle it passes the PWM request through as a high-side drive enable. If the overcurrent comparator reports a trip while sensing is enabled, it cuts the drive at once, in the same clock cycle. The drive then stays off for the rest of that cycle. A new pulse is allowed only after the PWM request has gone low and risen again.

Right after the switch turns on, ringing on the switch node makes the comparator unreliable, so sensing starts off. Two events can enable it, and whichever comes first wins:

- A digital "switch node high" indication, followed by a short reaction delay.
- A blanking timeout, counted in clocks from the rising edge of the request.

After each switching cycle a one-clock flag reports whether that cycle was cut short.

The controller has five states:

- **IDLE**: waiting for a request.
- **BLANK**: drive on, sensing off, waiting for a release event.
- **REACT**: the switch node was seen high and the reaction delay is running.
- **ARMED**: sensing enabled.
- **TRIP**: the pulse was ended by an overcurrent.

Transitions:

- IDLE→BLANK: request rises with the switch node low.
- IDLE→REACT: request rises with the switch node already high.
- BLANK→REACT: switch node seen high.
- BLANK→ARMED: timeout.
- REACT→ARMED: reaction delay done, or timeout.
- ARMED→TRIP: overcurrent.
- Any non-IDLE state→IDLE: request low.

Top module: `oc_blank_gate`

## Requirements
- R1: While `pwm_req` is low, `hs_drive` is low. In the first cycle `pwm_req` is high (cycle 0 of a pulse), `hs_drive` is high in that same cycle.
- R2: Once sensing is enabled, a high `oc_cmp` while `pwm_req` is high drives `hs_drive` low in that same cycle.
- R3: After an overcurrent termination, `hs_drive` stays low for as long as `pwm_req` stays high, even if `oc_cmp` returns low. The next pulse drives normally.
- R4: With `sw_high` never high, `oc_cmp` is ignored in cycles 0 to BLANK_CYC-1 of a pulse and honoured from cycle BLANK_CYC onward. BLANK_CYC is at least 2.
- R5: If `sw_high` is first high in cycle s of a pulse (s ≥ 0, sensing still off), `oc_cmp` is honoured from cycle s+REACT_CYC+1. This holds when that cycle comes before BLANK_CYC.
- R6: Sensing is enabled at the earlier of the two release cycles. A late `sw_high` does not push the timeout back.
- R7: The blanking timer restarts at every rising edge of `pwm_req`, including after a single low cycle.
- R8: `oc_flag` is high for exactly one cycle: the cycle after the first low cycle of `pwm_req` that follows a pulse ended by overcurrent. It is low after pulses that were not cut.
- R9: `oc_cmp` activity while `pwm_req` is low has no effect. It sets no flag and does not change the next pulse.
- R10: `rst_n` is a synchronous active-low reset. While it is low, `hs_drive` is low and `oc_flag` is low. After reset, the block starts in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_req | input | 1 | Per-cycle PWM request from the modulator |
| sw_high | input | 1 | Switch node reported near the supply |
| oc_cmp | input | 1 | Overcurrent comparator result |
| hs_drive | output | 1 | Gated high-side drive enable |
| oc_flag | output | 1 | One-cycle end-of-cycle overcurrent report |

## Verification
The comparator is held high from the very first cycle of a pulse, so the cycle in which the drive drops shows which release event enabled sensing. The bench tries no switch-node report, a report in cycle 0, an early report and a report that comes after the timeout. Together these separate the reaction-delay path from the timeout path and show that the earlier one wins. A single late comparator pulse that goes away again shows that a terminated pulse latches off. A short pulse followed by one low cycle shows that the timer restarts on each rising edge. Comparator activity while the request is low, and a reset in the middle of a trip, cover the cases where inputs must be ignored.

// File: rtl/ocb_pkg.sv
package ocb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BLANK,
        ST_REACT,
        ST_ARMED,
        ST_TRIP
    } ocb_state_e;
endpackage

// File: rtl/ocb_cnt.sv
// Saturating up-counter that reports when it sits at its terminal value.
module ocb_cnt #(
    parameter int LAST = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic hit
);
    localparam int W = (LAST < 1) ? 1 : $clog2(LAST + 1);
    localparam logic [W-1:0] LAST_V = W'(LAST);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en && (cnt != LAST_V)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = (cnt == LAST_V);
endmodule

// File: rtl/ocb_fsm.sv
// Blanking controller: state register, transition logic, drive gating, flag.
module ocb_fsm
    import ocb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_req,
    input  logic       sw_high,
    input  logic       oc_cmp,
    input  logic       tmo_hit,
    input  logic       react_hit,
    output ocb_state_e state,
    output logic       hs_drive,
    output logic       oc_flag
);
    ocb_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (pwm_req) nxt = sw_high ? ST_REACT : ST_BLANK;
            end
            ST_BLANK: begin
                if (!pwm_req)    nxt = ST_IDLE;
                else if (tmo_hit) nxt = ST_ARMED;
                else if (sw_high) nxt = ST_REACT;
            end
            ST_REACT: begin
                if (!pwm_req)                  nxt = ST_IDLE;
                else if (tmo_hit || react_hit) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (!pwm_req)   nxt = ST_IDLE;
                else if (oc_cmp) nxt = ST_TRIP;
            end
            ST_TRIP: begin
                if (!pwm_req) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs: drive is cut combinationally on a sensed trip.
    always_comb begin
        hs_drive = rst_n && pwm_req && (state != ST_TRIP)
                   && !((state == ST_ARMED) && oc_cmp);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_flag <= 1'b0;
        end else begin
            oc_flag <= (state == ST_TRIP) && !pwm_req;
        end
    end
endmodule

// File: rtl/oc_blank_gate.sv
module oc_blank_gate #(
    parameter int BLANK_CYC = 12,
    parameter int REACT_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic sw_high,
    input  logic oc_cmp,
    output logic hs_drive,
    output logic oc_flag
);
    import ocb_pkg::*;

    // Cycle 0 of a pulse is spent in IDLE, so the timer ends one count early.
    localparam int TMO_LAST   = BLANK_CYC - 2;
    localparam int REACT_LAST = REACT_CYC - 1;

    ocb_state_e fsm_state;
    logic       tmo_hit;
    logic       react_hit;

    ocb_cnt #(.LAST(TMO_LAST)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fsm_state == ST_IDLE),
        .en    ((fsm_state == ST_BLANK) || (fsm_state == ST_REACT)),
        .hit   (tmo_hit)
    );

    ocb_cnt #(.LAST(REACT_LAST)) u_react (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fsm_state != ST_REACT),
        .en    (fsm_state == ST_REACT),
        .hit   (react_hit)
    );

    ocb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_req   (pwm_req),
        .sw_high   (sw_high),
        .oc_cmp    (oc_cmp),
        .tmo_hit   (tmo_hit),
        .react_hit (react_hit),
        .state     (fsm_state),
        .hs_drive  (hs_drive),
        .oc_flag   (oc_flag)
    );
endmodule

// File: rtl/oc_blank_gate_chk.sv
module oc_blank_gate_chk
    import ocb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pwm_req,
    input logic       oc_cmp,
    input logic       hs_drive,
    input logic       oc_flag,
    input ocb_state_e state
);
    // R1
    req_low_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_req |-> !hs_drive);

    // R2
    trip_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && pwm_req && oc_cmp) |=> (state == ST_TRIP || !pwm_req));

    // R3
    stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_req && !hs_drive) ##1 pwm_req |-> !hs_drive);

    // R4
    blank_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLANK && pwm_req) |-> hs_drive);

    // R5
    react_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REACT && pwm_req) |-> hs_drive);

    // R8
    flag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flag |=> !oc_flag);

    // R8
    flag_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flag |-> $past(!pwm_req));
endmodule

bind oc_blank_gate oc_blank_gate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_req  (pwm_req),
    .oc_cmp   (oc_cmp),
    .hs_drive (hs_drive),
    .oc_flag  (oc_flag),
    .state    (fsm_state)
);

// File: tb/oc_blank_gate_bench.sv
`timescale 1ns/1ps
module oc_blank_gate_bench;
    localparam int BLK = 12;
    localparam int RCT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_req = 1'b0;
    logic sw_high = 1'b0;
    logic oc_cmp = 1'b0;
    logic hs_drive;
    logic oc_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    oc_blank_gate #(.BLANK_CYC(BLK), .REACT_CYC(RCT)) u_oc_blank_gate (
        .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .sw_high(sw_high),
        .oc_cmp(oc_cmp), .hs_drive(hs_drive), .oc_flag(oc_flag)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    // Apply one cycle of inputs and sample outputs mid-cycle.
    task automatic cyc(input logic p, input logic s, input logic o);
        @(negedge clk);
        pwm_req = p; sw_high = s; oc_cmp = o;
        #1;
    endtask

    // One pulse; exp_off = first cycle with drive low (-1: never).
    task automatic run_pulse(input int len, input int sw_at, input int oc_from,
                             input int oc_to, input int exp_off, input bit tail,
                             input string tag);
        for (int j = 0; j < len; j++) begin
            cyc(1'b1, (sw_at >= 0) && (j >= sw_at), (j >= oc_from) && (j <= oc_to));
            chk(hs_drive, (exp_off < 0) || (j < exp_off), $sformatf("%s drive c%0d", tag, j));
        end
        cyc(1'b0, 1'b0, 1'b0);
        chk(hs_drive, 1'b0, {tag, " R1 low"});
        if (tail) begin
            cyc(1'b0, 1'b0, 1'b0);
            chk(oc_flag, exp_off >= 0, {tag, " R8 flag"});
            cyc(1'b0, 1'b0, 1'b0);
            chk(oc_flag, 1'b0, {tag, " R8 flag clear"});
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, 1'b0, 1'b1);
            chk(hs_drive, 1'b0, "R10 drive in reset");
            chk(oc_flag, 1'b0, "R10 flag in reset");
        end
        @(negedge clk); rst_n = 1'b1; pwm_req = 1'b0; oc_cmp = 1'b0;
        cyc(1'b0, 1'b0, 1'b0);
        chk(hs_drive, 1'b0, "R10 after release");
    endtask

    task automatic t_timeout();
        run_pulse(20, -1, 0, 99, BLK, 1'b1, "R4 R2 timeout");
    endtask

    task automatic t_sw_early();
        run_pulse(16, 3, 0, 99, 3 + RCT + 1, 1'b1, "R5 sw early");
        run_pulse(16, 0, 0, 99, RCT + 1, 1'b1, "R5 sw at 0");
    endtask

    task automatic t_sw_late();
        run_pulse(18, 10, 0, 99, BLK, 1'b1, "R6 sw late");
    endtask

    task automatic t_latch();
        run_pulse(22, -1, 15, 15, 15, 1'b1, "R3 latch");
        run_pulse(10, -1, 99, 99, -1, 1'b1, "R3 next pulse");
    endtask

    task automatic t_restart();
        run_pulse(6, -1, 99, 99, -1, 1'b0, "R7 short");
        run_pulse(16, -1, 0, 99, BLK, 1'b1, "R7 restart");
    endtask

    task automatic t_low_oc();
        for (int k = 0; k < 4; k++) begin
            cyc(1'b0, 1'b1, 1'b1);
            chk(hs_drive, 1'b0, "R9 drive while low");
        end
        cyc(1'b0, 1'b0, 1'b0);
        chk(oc_flag, 1'b0, "R9 no flag");
        run_pulse(14, -1, 99, 99, -1, 1'b1, "R9 clean pulse");
    endtask

    task automatic t_reset_mid();
        run_pulse(14, -1, 0, 99, BLK, 1'b0, "R10 trip setup");
        cyc(1'b1, 1'b0, 1'b1);
        chk(hs_drive, 1'b1, "R1 rise drives");
        for (int k = 1; k < BLK + 2; k++) cyc(1'b1, 1'b0, 1'b1);
        chk(hs_drive, 1'b0, "R2 tripped before reset");
        @(negedge clk); rst_n = 1'b0; #1;
        chk(hs_drive, 1'b0, "R10 reset forces off");
        @(negedge clk); rst_n = 1'b1; #1;
        chk(hs_drive, 1'b1, "R10 fresh pulse after reset");
        chk(oc_flag, 1'b0, "R10 flag after reset");
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_timeout();
        t_sw_early();
        t_sw_late();
        t_latch();
        t_restart();
        t_low_oc();
        t_reset_mid();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule